// File: doc/BRIEF.md
# Device-Select Addressed I2C Target

This block is an I2C target that runs entirely on a fast system clock. It samples the bus lines and finds Start, Stop and clock edges on that clock. It accepts an address byte that carries a fixed four-bit type code, two device bits that must match a pair of strap inputs, a bank bit and the read/write flag. It serves a small array of byte registers split into two banks, and it pulls SDA low only through an open-drain enable, never by driving a one.

A write transaction sets a shared byte pointer from its first data byte. It then stores each further byte at the pointer, and the pointer steps forward after every byte. A read transaction returns bytes from the pointer and keeps going while the controller acknowledges. When a Stop closes a write that stored data, the block raises a single-cycle commit request, which a downstream non-volatile programming engine picks up.

Top module: `i2c_devsel_target`

## Requirements
- R1: After reset, `sda_oe_o` and `commit_o` are 0, the byte pointer is 0 and every register in both banks reads as 0x00.
- R2: A Start (SDA falling while SCL is high) starts address reception from any state, including in the middle of a transaction. A Stop (SDA rising while SCL is high) returns the block to idle. Clock pulses that arrive with no Start before them are ignored and leave SDA released.
- R3: Bytes are 8 bits, most significant bit first. The bus line is sampled on the SCL rising edge. The block turns its SDA pull-down on only while SCL is low, and it never pulls SDA while the controller is sending a data bit.
- R4: Address byte layout, from bit 7 down: bits 7..4 are the type code (default 4'b1010), bits 3..2 must equal `dev_sel_i[1:0]`, bit 1 selects bank 0 or bank 1, and bit 0 is 1 for a read and 0 for a write.
- R5: The block pulls SDA low during the ninth clock of the address byte only when both the type code and the device bits match. On a mismatch it leaves SDA released for every later bit until the next Start.
- R6: In a write, every data byte is acknowledged. The first data byte loads the pointer from its low bits. Each later byte is stored at the pointer in the selected bank, and the pointer then increments, wrapping from DEPTH-1 to 0.
- R7: In a read, the block sends the selected bank's byte at the pointer and then increments the pointer, wrapping at DEPTH. It releases SDA during the ninth clock. If it samples an ACK (low), it sends the next byte. If it samples a NACK (high), it stays off the bus until a Start or Stop.
- R8: A Stop that ends a write transaction which stored at least one data byte produces exactly one `commit_o` pulse, one clock wide.
- R9: No commit is produced by a Stop after a read, after a write that only loaded the pointer, or after a mismatched address. A repeated Start discards a pending commit.
- R10: The two banks are independent. A write through one bank's address leaves the other bank's byte at the same pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_sel_i | input | 2 | Strap inputs that set this device's two address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| commit_o | output | 1 | One-cycle request to start a non-volatile write cycle |

## Verification
The assertions check, on every cycle, that the pull-down turns on only while the synchronised SCL is low, and that the bit counter never passes eight. They also check that SDA is released throughout the read-acknowledge clock, that a mismatched type code is never acknowledged, and that a commit pulse is one cycle wide and appears only once the block has returned to idle. The bench's scenarios are what show that data lands at the right pointer and wraps, that the banks stay separate, that reads return what was written, and that the commit follows data-bearing writes only, never pointer-only writes, reads, foreign addresses or repeated Starts.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_HOLD
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output i2c_tgt_pkg::bus_ev_t  ev_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl;
        logic [SYNC_STAGES-1:0] sda;
        logic                   scl_p;
        logic                   sda_p;
    } sync_t;

    sync_t q, d;
    logic  scl_s, sda_s;

    assign scl_s = q.scl[SYNC_STAGES-1];
    assign sda_s = q.sda[SYNC_STAGES-1];

    always_comb begin
        d       = q;
        d.scl   = {q.scl[SYNC_STAGES-2:0], scl_i};
        d.sda   = {q.sda[SYNC_STAGES-2:0], sda_i};
        d.scl_p = scl_s;
        d.sda_p = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~q.scl_p;
        ev_o.scl_fall = ~scl_s & q.scl_p;
        ev_o.start    = scl_s & q.scl_p & q.sda_p & ~sda_s;
        ev_o.stop     = scl_s & q.scl_p & ~q.sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          wbank_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic          rbank_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [NB-1:0][7:0] rd_all;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [7:0] mem_q [DEPTH];
        logic [7:0] mem_d [DEPTH];

        always_comb begin
            mem_d = mem_q;
            if (we_i && (wbank_i == 1'(b))) mem_d[waddr_i] = wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else begin
                mem_q <= mem_d;
            end
        end

        assign rd_all[b] = mem_q[raddr_i];
    end

    assign rdata_o = rd_all[rbank_i];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE = 4'b1010,
    parameter int         DEPTH     = 16,
    localparam int        AW        = $clog2(DEPTH),
    localparam int        BITS      = 8,
    localparam int        CW        = $clog2(BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_ev_t       ev_i,
    input  logic [1:0]    dev_sel_i,
    input  logic [7:0]    rdata_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic          bank_o,
    output logic [AW-1:0] raddr_o,
    output logic          sda_oe_o,
    output logic          commit_o
);
    typedef struct packed {
        tgt_state_e    state;
        logic [CW-1:0] bitcnt;
        logic [7:0]    shreg;
        logic          bank;
        logic          rw;
        logic [AW-1:0] ptr;
        logic          first;
        logic          pend;
        logic          ack_seen;
        logic          oe;
        logic          commit;
        logic          we;
        logic [AW-1:0] waddr;
        logic [7:0]    wdata;
    } ctrl_t;

    ctrl_t q, d;
    logic  byte_done;

    assign byte_done = (q.bitcnt == CW'(BITS));

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        d.we     = 1'b0;
        if (ev_i.stop) begin
            d.commit = q.pend;
            d.pend   = 1'b0;
            d.state  = ST_IDLE;
            d.oe     = 1'b0;
        end else if (ev_i.start) begin
            d.state  = ST_ADDR;
            d.bitcnt = '0;
            d.pend   = 1'b0;
            d.oe     = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR: begin
                    if (ev_i.scl_rise) begin
                        d.shreg  = {q.shreg[6:0], ev_i.sda};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (ev_i.scl_fall && byte_done) begin
                        if (q.shreg[7:4] == TYPE_CODE && q.shreg[3:2] == dev_sel_i) begin
                            d.state = ST_ADDR_ACK;
                            d.oe    = 1'b1;
                            d.bank  = q.shreg[1];
                            d.rw    = q.shreg[0];
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_i.scl_fall) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.state = ST_RD;
                            d.shreg = rdata_i;
                            d.oe    = ~rdata_i[7];
                        end else begin
                            d.state = ST_WR;
                            d.oe    = 1'b0;
                            d.first = 1'b1;
                        end
                    end
                end
                ST_WR: begin
                    if (ev_i.scl_rise) begin
                        d.shreg  = {q.shreg[6:0], ev_i.sda};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (ev_i.scl_fall && byte_done) begin
                        d.state = ST_WR_ACK;
                        d.oe    = 1'b1;
                        if (q.first) begin
                            d.ptr   = q.shreg[AW-1:0];
                            d.first = 1'b0;
                        end else begin
                            d.we    = 1'b1;
                            d.waddr = q.ptr;
                            d.wdata = q.shreg;
                            d.ptr   = q.ptr + 1'b1;
                            d.pend  = 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev_i.scl_fall) begin
                        d.state  = ST_WR;
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                    end
                end
                ST_RD: begin
                    if (ev_i.scl_rise) begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (ev_i.scl_fall) begin
                        if (byte_done) begin
                            d.state = ST_RD_ACK;
                            d.oe    = 1'b0;
                            d.ptr   = q.ptr + 1'b1;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_i.scl_rise) begin
                        d.ack_seen = ~ev_i.sda;
                    end else if (ev_i.scl_fall) begin
                        if (q.ack_seen) begin
                            d.state  = ST_RD;
                            d.bitcnt = '0;
                            d.shreg  = rdata_i;
                            d.oe     = ~rdata_i[7];
                        end else begin
                            d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign we_o     = q.we;
    assign waddr_o  = q.waddr;
    assign wdata_o  = q.wdata;
    assign bank_o   = q.bank;
    assign raddr_o  = q.ptr;
    assign sda_oe_o = q.oe;
    assign commit_o = q.commit;

    // R3: the pull-down only switches on while the synchronised clock is low
    p_drive_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !ev_i.scl);

    // R3: at most eight bits are counted per byte
    p_bitcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.bitcnt <= CW'(BITS));

    // R5: a foreign type code never gets an acknowledge
    p_no_ack_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ADDR && ev_i.scl_fall && byte_done && q.shreg[7:4] != TYPE_CODE
         && !ev_i.start && !ev_i.stop) |=> !q.oe);

    // R7: SDA is released while the controller answers a read byte
    p_release_ninth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RD_ACK) |-> !q.oe);

    // R8: commit is a single-cycle pulse
    p_commit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |=> !q.commit);

    // R8: commit only appears once the block is back at idle
    p_commit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> (q.state == ST_IDLE && !q.oe));
endmodule

// File: rtl/i2c_devsel_target.sv
module i2c_devsel_target #(
    parameter logic [3:0] TYPE_CODE   = 4'b1010,
    parameter int         DEPTH       = 16,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_sel_i,
    output logic       sda_oe_o,
    output logic       commit_o
);
    i2c_tgt_pkg::bus_ev_t ev;
    logic          we;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata;
    logic          bank;
    logic [AW-1:0] raddr;
    logic [7:0]    rdata;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_tgt_ctrl #(.TYPE_CODE(TYPE_CODE), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .dev_sel_i (dev_sel_i),
        .rdata_i   (rdata),
        .we_o      (we),
        .waddr_o   (waddr),
        .wdata_o   (wdata),
        .bank_o    (bank),
        .raddr_o   (raddr),
        .sda_oe_o  (sda_oe_o),
        .commit_o  (commit_o)
    );

    i2c_reg_bank #(.DEPTH(DEPTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .wbank_i (bank),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .rbank_i (bank),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );
endmodule

// File: tb/tb_i2c_devsel_target.sv
module tb_i2c_devsel_target;
    localparam int Q     = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] dev_sel = 2'b10;
    logic       sda_oe;
    logic       commit;
    wire        sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_devsel_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .dev_sel_i (dev_sel),
        .sda_oe_o  (sda_oe),
        .commit_o  (commit)
    );

    int    total = 0;
    int    bad = 0;
    int    commit_cnt = 0;
    logic  chk_off = 1'b0;
    string chk_req = "R3";
    logic  prev_commit = 1'b0;
    bit    done = 1'b0;
    int    mem [2][DEPTH];
    int    ptr = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model's expectations
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_off) check(sda_oe == 1'b0, chk_req, int'(sda_oe), 0);
            if (commit) begin
                commit_cnt++;
                check(!prev_commit, "R8", 1, 0);
            end
            prev_commit = commit;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic bit_cycle(input logic b, input logic off, input string req, output logic s);
        sda_m = b; tick(Q);
        scl_m = 1'b1; chk_req = req; chk_off = off; tick(Q);
        s = sda_line; tick(Q);
        chk_off = 1'b0; scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, input logic ack_off, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], 1'b1, "R3", s);
        bit_cycle(1'b1, ack_off, "R5", s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, 1'b0, "R7", s);
            v[i] = s;
        end
        bit_cycle(~mack, 1'b1, "R7", s);
    endtask

    function automatic logic [7:0] addr(input logic [1:0] dv, input logic bk, input logic rw);
        return {4'b1010, dv, bk, rw};
    endfunction

    // n bytes: first loads pointer, rest are data
    task automatic wr_txn(input logic [1:0] dv, input logic bk, input int n,
                          input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          input bit do_stop);
        logic a;
        logic [7:0] v;
        bit match;
        int c0;
        int pend;
        c0 = commit_cnt;
        pend = 0;
        match = (dv == dev_sel);
        bus_start;
        put_byte(addr(dv, bk, 1'b0), ~match, a);
        check(a == match, "R5", int'(a), int'(match));
        for (int k = 0; k < n; k++) begin
            v = (k == 0) ? b0 : (k == 1) ? b1 : b2;
            put_byte(v, ~match, a);
            check(a == match, "R6", int'(a), int'(match));
            if (match) begin
                if (k == 0) ptr = int'(v) % DEPTH;
                else begin
                    mem[bk][ptr] = int'(v);
                    ptr = (ptr + 1) % DEPTH;
                    pend = 1;
                end
            end
        end
        if (do_stop) begin
            bus_stop;
            tick(8);
            if (pend != 0) check(commit_cnt - c0 == 1, "R8", commit_cnt - c0, 1);
            else           check(commit_cnt - c0 == 0, "R9", commit_cnt - c0, 0);
        end
    endtask

    task automatic rd_txn(input logic bk, input int n, input bit do_stop);
        logic a;
        logic [7:0] v;
        int c0;
        c0 = commit_cnt;
        bus_start;
        put_byte(addr(dev_sel, bk, 1'b1), 1'b0, a);
        check(a == 1'b1, "R5", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k < n - 1, v);
            check(int'(v) == mem[bk][ptr], "R7", int'(v), mem[bk][ptr]);
            ptr = (ptr + 1) % DEPTH;
        end
        if (do_stop) begin
            bus_stop;
            tick(8);
            check(commit_cnt - c0 == 0, "R9", commit_cnt - c0, 0);
        end
    endtask

    task automatic foreign_addr(input logic [7:0] av, input string req);
        logic a;
        int c0;
        c0 = commit_cnt;
        bus_start;
        put_byte(av, 1'b1, a);
        check(!a, req, int'(a), 0);
        put_byte(8'h55, 1'b1, a);
        check(!a, req, int'(a), 0);
        bus_stop;
        tick(8);
        check(commit_cnt - c0 == 0, "R9", commit_cnt - c0, 0);
    endtask

    initial begin
        logic a;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < DEPTH; i++) mem[b][i] = 0;
        tick(5);
        check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
        check(commit == 1'b0, "R1", int'(commit), 0);
        rst_n = 1'b1;
        tick(5);
        check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);

        // R1: fresh registers read zero; R9: pointer-only write + repeated Start
        wr_txn(dev_sel, 1'b1, 1, 8'h09, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b1, 2, 1'b1);

        // R6 / R8: data write with commit
        wr_txn(dev_sel, 1'b0, 3, 8'h02, 8'hA5, 8'h3C, 1'b1);
        wr_txn(dev_sel, 1'b0, 1, 8'h02, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b0, 2, 1'b1);

        // R6 / R7: pointer wrap at the bank end
        wr_txn(dev_sel, 1'b0, 3, 8'h0F, 8'h11, 8'h22, 1'b1);
        wr_txn(dev_sel, 1'b0, 1, 8'h0F, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b0, 3, 1'b1);

        // R10: bank 1 write leaves bank 0 alone
        wr_txn(dev_sel, 1'b1, 3, 8'h02, 8'h77, 8'h88, 1'b1);
        wr_txn(dev_sel, 1'b0, 1, 8'h02, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b0, 1, 1'b1);
        wr_txn(dev_sel, 1'b1, 1, 8'h02, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b1, 2, 1'b1);

        // R5: wrong type code, wrong device bits
        foreign_addr({4'b1011, dev_sel, 2'b00}, "R5");
        foreign_addr({4'b1010, ~dev_sel, 2'b00}, "R4");
        wr_txn(~dev_sel, 1'b0, 2, 8'h04, 8'hEE, 8'h00, 1'b1);

        // R4: straps moved, the new device bits now match
        dev_sel = 2'b01;
        tick(4);
        wr_txn(2'b01, 1'b0, 2, 8'h07, 8'h5A, 8'h00, 1'b1);
        wr_txn(2'b01, 1'b0, 1, 8'h07, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b0, 1, 1'b1);

        // R9: data written, then repeated Start into a read: commit dropped
        wr_txn(dev_sel, 1'b0, 2, 8'h05, 8'h9A, 8'h00, 1'b0);
        rd_txn(1'b0, 1, 1'b1);
        wr_txn(dev_sel, 1'b0, 1, 8'h05, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b0, 1, 1'b1);

        // R2: a full matching address clocked with no Start is ignored
        put_byte(addr(dev_sel, 1'b0, 1'b0), 1'b1, a);
        check(!a, "R2", int'(a), 0);
        // R2: a Start still works afterwards
        wr_txn(dev_sel, 1'b0, 1, 8'h00, 8'h00, 8'h00, 1'b0);
        rd_txn(1'b0, 1, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule